// File: doc/BRIEF.md
# Reduced-Power and Emulation Mode Controller

This block sequences the operating mode of a small embedded controller. Software may ask for a light sleep, in which the processor clock stops while the oscillator keeps running, or for a deep sleep, in which the oscillator is also switched off. The block selects the mode and drives a gate for the processor clock and an enable for the oscillator. It also sets the drive level of the address-latch strobe, the program-fetch strobe and the port pins. A fourth mode hands the board to an external test processor. In that mode the block floats or weakly pulls up its pins and keeps the oscillator alive.

Leaving deep sleep through an external interrupt is a two-phase handshake. An enabled, level-configured interrupt pin going low restarts the oscillator. When the pin returns high, the wake-up completes, but only if the oscillator has already reported that it is stable. The external reset pin only acts after it has been held for two machine cycles of a running oscillator. Test mode is chosen by the strobe pin levels seen while reset is active and at the moment reset is released.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the system reset is released, `mode_o` reads 0 (running), `cpu_clk_en` and `osc_en` are 1, both strobe modes read 0 (normal), and `port0_float`, `ports_weak_hi`, `ram_wr_block` and `pd_wake` are 0.
- R2: An `idle_req` pulse while running moves `mode_o` to 1 (light sleep) at the next clock edge. In that mode `cpu_clk_en`=0, `osc_en`=1 and both strobe modes read 1 (driven high).
- R3: In light sleep, a high `irq_pending` returns `mode_o` to 0 with `cpu_clk_en`=1 at the next edge.
- R4: A `pd_req` pulse while running moves `mode_o` to 2 (deep sleep) at the next edge, even when `idle_req` is high at the same time. In that mode `cpu_clk_en`=0, both strobe modes read 2 (driven low), and `osc_en`=0 while no reset or wake-up is pending.
- R5: In deep sleep, only a low pin i (`xint_n[i]`=0) with `xint_en[i]`=1 and `xint_lvl[i]`=1 (level-sensitive) restarts the oscillator. Such a pin drives `osc_en` to 1 in the same cycle, and `mode_o` becomes 3 (waking) at the next edge. A pin that is disabled or edge-configured has no effect.
- R6: In the waking mode, strobe modes stay 2 and `osc_en`=1. Suppose `osc_stable` was sampled high on an edge that precedes the edge at which all wake pins read high again. Then that edge moves `mode_o` to 0, and `pd_wake` is 1 for exactly that one following cycle.
- R7: If the wake pins return high before `osc_stable` has been sampled high on an earlier edge in the waking mode, `mode_o` returns to 2 at that edge.
- R8: A reset takes effect only after `rst_pin` has been high with `osc_stable` high for 2·`MC_CLKS` consecutive edges. At that edge `mode_o` becomes 4 (reset), with `cpu_clk_en`=0 and `ram_wr_block`=1. A shorter pulse changes nothing. A low `rst_pin` in mode 4 leaves reset at the next edge.
- R9: Test mode is entered on leaving mode 4 when `ale_in`=0 and `psen_in`=1 were sampled on an edge inside mode 4, and `ale_in` is still 0 at the leaving edge. Test mode is `mode_o`=5, with `port0_float`=1, `ports_weak_hi`=1, both strobe modes 3 (weak high), `osc_en`=1 and `cpu_clk_en`=0. Leaving mode 4 with `ale_in`=1 gives mode 0.
- R10: Test mode ignores `idle_req`, `pd_req`, `irq_pending`, interrupt pins and unqualified reset pulses. It ends only through a qualified reset (R8).
- R11: A high `rst_pin` in light sleep restarts the processor clock at the next edge (`mode_o`=0, `cpu_clk_en`=1) with `ram_wr_block`=1. The block stays on until the reset is taken, and stays on through mode 4. It clears at the first edge that sees `rst_pin` low.
- R12: A high `rst_pin` in deep sleep sets `osc_en` to 1 in the same cycle. Reset qualification counts only edges where `osc_stable` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| rst_pin | input | 1 | External reset pin, active high |
| idle_req | input | 1 | Software request for light sleep |
| pd_req | input | 1 | Software request for deep sleep |
| irq_pending | input | 1 | Any enabled interrupt is pending |
| xint_n | input | NUM_XINT | External interrupt pins, active low |
| xint_en | input | NUM_XINT | Per-pin interrupt enable |
| xint_lvl | input | NUM_XINT | Per-pin level-sensitive select |
| ale_in | input | 1 | Address-latch strobe pin level |
| psen_in | input | 1 | Program-fetch strobe pin level |
| osc_stable | input | 1 | Oscillator reports stable clock |
| cpu_clk_en | output | 1 | Processor clock gate |
| osc_en | output | 1 | Oscillator enable |
| ale_mode | output | 2 | Address-latch strobe drive: 0 normal, 1 high, 2 low, 3 weak high |
| psen_mode | output | 2 | Program-fetch strobe drive, same coding |
| port0_float | output | 1 | Multiplexed bus port floats |
| ports_weak_hi | output | 1 | Other ports weakly pulled high |
| ram_wr_block | output | 1 | Internal RAM write inhibit |
| pd_wake | output | 1 | One-cycle pulse when deep sleep ends by interrupt |
| mode_o | output | 3 | Current mode code |

## Verification
Mode changes appear in `mode_o` and the decoded drive outputs at the first clock edge after the stimulus. Every one-cycle step is therefore checked one full clock later, at the falling edge. `osc_en` follows wake pins and the reset pin within the same cycle, so it is checked one nanosecond after the falling-edge drive, before any rising edge. The reset filter is due exactly at the 2·`MC_CLKS`-th qualifying edge. The bench samples once one edge earlier, where nothing may have changed, and once at that edge. The wake handshake is checked on both sides of its one-edge requirement, with the stable indication raised together with the pin release, and then one edge before it.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_IDLE = 3'd1,
    ST_PD   = 3'd2,
    ST_WAKE = 3'd3,
    ST_RST  = 3'd4,
    ST_EMU  = 3'd5
  } pmc_state_e;

  typedef enum logic [1:0] {
    DRV_NORMAL = 2'd0,
    DRV_HIGH   = 2'd1,
    DRV_LOW    = 2'd2,
    DRV_WEAK   = 2'd3
  } pin_drive_e;
endpackage

// File: rtl/pmc_rst_filter.sv
`timescale 1ns/1ps
module pmc_rst_filter #(
  parameter int unsigned HOLD_CLKS = 24
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic rst_pin,
  input  logic osc_stable,
  output logic rst_hit
);
  localparam int unsigned CW = (HOLD_CLKS > 2) ? $clog2(HOLD_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en  = rst_pin & osc_stable & (cnt_q != LAST);
  assign rst_hit = rst_pin & osc_stable & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!rst_pin)    cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R8
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    rst_hit |-> $past(rst_pin));
endmodule

// File: rtl/pmc_wake_detect.sv
`timescale 1ns/1ps
module pmc_wake_detect #(
  parameter int unsigned NUM_XINT = 2
) (
  input  logic [NUM_XINT-1:0] xint_n,
  input  logic [NUM_XINT-1:0] xint_en,
  input  logic [NUM_XINT-1:0] xint_lvl,
  output logic                wake_any
);
  logic [NUM_XINT-1:0] wake_vec;

  for (genvar i = 0; i < NUM_XINT; i++) begin : g_pin
    assign wake_vec[i] = xint_en[i] & xint_lvl[i] & ~xint_n[i];
  end

  assign wake_any = |wake_vec;
endmodule

// File: rtl/pmc_pin_ctrl.sv
`timescale 1ns/1ps
module pmc_pin_ctrl
  import pmc_pkg::*;
(
  input  pmc_state_e state,
  input  logic       rst_pin,
  input  logic       wake_any,
  input  logic       rst_exit,
  output logic       cpu_clk_en,
  output logic       osc_en,
  output logic [1:0] ale_mode,
  output logic [1:0] psen_mode,
  output logic       port0_float,
  output logic       ports_weak_hi,
  output logic       ram_wr_block
);
  pin_drive_e strobe;

  always_comb begin
    unique case (state)
      ST_IDLE:         strobe = DRV_HIGH;
      ST_PD, ST_WAKE:  strobe = DRV_LOW;
      ST_EMU:          strobe = DRV_WEAK;
      default:         strobe = DRV_NORMAL;
    endcase
  end

  assign ale_mode      = strobe;
  assign psen_mode     = strobe;
  assign cpu_clk_en    = (state == ST_RUN);
  assign osc_en        = (state != ST_PD) | rst_pin | wake_any;
  assign port0_float   = (state == ST_EMU);
  assign ports_weak_hi = (state == ST_EMU);
  assign ram_wr_block  = (state == ST_RST) | rst_exit;
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned NUM_XINT = 2,
  parameter int unsigned MC_CLKS  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rst_pin,
  input  logic                idle_req,
  input  logic                pd_req,
  input  logic                irq_pending,
  input  logic [NUM_XINT-1:0] xint_n,
  input  logic [NUM_XINT-1:0] xint_en,
  input  logic [NUM_XINT-1:0] xint_lvl,
  input  logic                ale_in,
  input  logic                psen_in,
  input  logic                osc_stable,
  output logic                cpu_clk_en,
  output logic                osc_en,
  output logic [1:0]          ale_mode,
  output logic [1:0]          psen_mode,
  output logic                port0_float,
  output logic                ports_weak_hi,
  output logic                ram_wr_block,
  output logic                pd_wake,
  output logic [2:0]          mode_o
);
  localparam int unsigned HOLD_CLKS = 2 * MC_CLKS;

  logic [1:0] sync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sn = sync_q[1];

  logic rst_hit, wake_any;

  pmc_rst_filter #(.HOLD_CLKS(HOLD_CLKS)) u_rst_filter (
    .clk(clk), .rst_sn(rst_sn), .rst_pin(rst_pin),
    .osc_stable(osc_stable), .rst_hit(rst_hit));

  pmc_wake_detect #(.NUM_XINT(NUM_XINT)) u_wake (
    .xint_n(xint_n), .xint_en(xint_en), .xint_lvl(xint_lvl),
    .wake_any(wake_any));

  pmc_state_e state_q, state_d;
  logic stable_q, stable_d;
  logic strap_q, strap_d;
  logic rexit_q, rexit_d;
  logic wake_q, wake_d;

  always_comb begin
    state_d = state_q;
    if (rst_hit) begin
      state_d = ST_RST;
    end else begin
      unique case (state_q)
        ST_RUN:  if (pd_req) state_d = ST_PD;
                 else if (idle_req) state_d = ST_IDLE;
        ST_IDLE: if (rst_pin || irq_pending) state_d = ST_RUN;
        ST_PD:   if (wake_any) state_d = ST_WAKE;
        ST_WAKE: if (!wake_any) state_d = stable_q ? ST_RUN : ST_PD;
        ST_RST:  if (!rst_pin) state_d = (strap_q && !ale_in) ? ST_EMU : ST_RUN;
        default: state_d = state_q;
      endcase
    end
  end

  always_comb begin
    stable_d = (state_q == ST_WAKE) & (stable_q | osc_stable);
    strap_d  = (state_q == ST_RST) & ~ale_in & (psen_in | strap_q);
    rexit_d  = rst_pin & ~rst_hit &
               (((state_q == ST_IDLE)) | (rexit_q & (state_q != ST_RST)));
    wake_d   = (state_q == ST_WAKE) & ~wake_any & stable_q & ~rst_hit;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q  <= ST_RUN;
      stable_q <= 1'b0;
      strap_q  <= 1'b0;
      rexit_q  <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      stable_q <= stable_d;
      strap_q  <= strap_d;
      rexit_q  <= rexit_d;
      wake_q   <= wake_d;
    end
  end

  pmc_pin_ctrl u_pins (
    .state(state_q), .rst_pin(rst_pin), .wake_any(wake_any),
    .rst_exit(rexit_q), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .ale_mode(ale_mode), .psen_mode(psen_mode), .port0_float(port0_float),
    .ports_weak_hi(ports_weak_hi), .ram_wr_block(ram_wr_block));

  assign pd_wake = wake_q;
  assign mode_o  = state_q;

  // R4
  pd_osc_off_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_PD && !rst_pin && !wake_any) |-> !osc_en);

  // R6
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    pd_wake |-> (state_q == ST_RUN && $past(state_q) == ST_WAKE));

  // R6
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    pd_wake |=> !pd_wake);

  // R7
  early_release_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_WAKE && !wake_any && !stable_q && !rst_hit) |=> state_q == ST_PD);

  // R10
  emu_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_EMU && !rst_hit) |=> state_q == ST_EMU);

  // R11
  ram_block_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ram_wr_block |-> (state_q == ST_RST || $past(rst_pin)));
endmodule

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  localparam int HOLD = 24;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, rst_pin, idle_req, pd_req, irq_pending;
  logic [1:0] xint_n, xint_en, xint_lvl;
  logic ale_in, psen_in, osc_stable;
  logic cpu_clk_en, osc_en, port0_float, ports_weak_hi, ram_wr_block, pd_wake;
  logic [1:0] ale_mode, psen_mode;
  logic [2:0] mode_o;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .idle_req(idle_req),
    .pd_req(pd_req), .irq_pending(irq_pending), .xint_n(xint_n),
    .xint_en(xint_en), .xint_lvl(xint_lvl), .ale_in(ale_in),
    .psen_in(psen_in), .osc_stable(osc_stable), .cpu_clk_en(cpu_clk_en),
    .osc_en(osc_en), .ale_mode(ale_mode), .psen_mode(psen_mode),
    .port0_float(port0_float), .ports_weak_hi(ports_weak_hi),
    .ram_wr_block(ram_wr_block), .pd_wake(pd_wake), .mode_o(mode_o));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // {en[1:0], lvl[1:0], pins_n[1:0], expected osc_en}
  localparam logic [6:0] VEC [7] = '{
    7'b11_11_11_0, 7'b00_11_00_0, 7'b11_00_00_0, 7'b01_01_10_1,
    7'b10_10_01_1, 7'b01_11_01_0, 7'b10_01_01_0 };

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; rst_pin = 0; idle_req = 0; pd_req = 0; irq_pending = 0;
    xint_n = 2'b11; xint_en = 0; xint_lvl = 0;
    ale_in = 1; psen_in = 1; osc_stable = 1;
    tick(3);
    rst_n = 1;
    tick(4);
    // R1 reset state
    check("R1 mode", mode_o, 0);
    check("R1 cpu/osc", {cpu_clk_en, osc_en}, 2'b11);
    check("R1 strobes", {ale_mode, psen_mode}, 0);
    check("R1 flags", {port0_float, ports_weak_hi, ram_wr_block, pd_wake}, 0);

    // R2 light sleep
    idle_req = 1; tick(); idle_req = 0;
    check("R2 mode", mode_o, 1);
    check("R2 cpu/osc", {cpu_clk_en, osc_en}, 2'b01);
    check("R2 strobes", {ale_mode, psen_mode}, 4'b0101);

    // R3 leave on interrupt
    irq_pending = 1; tick(); irq_pending = 0;
    check("R3 mode", mode_o, 0);
    check("R3 cpu", cpu_clk_en, 1);

    // R4 deep sleep beats light sleep
    pd_req = 1; idle_req = 1; tick(); pd_req = 0; idle_req = 0;
    check("R4 mode", mode_o, 2);
    check("R4 osc/cpu", {osc_en, cpu_clk_en}, 0);
    check("R4 strobes", {ale_mode, psen_mode}, 4'b1010);

    // R5 / R7 wake gating table, oscillator never stable
    osc_stable = 0;
    for (int k = 0; k < 7; k++) begin
      {xint_en, xint_lvl, xint_n} = VEC[k][6:1];
      #1 check($sformatf("R5 osc_en vec%0d", k), osc_en, VEC[k][0]);
      tick();
      check($sformatf("R5 mode vec%0d", k), mode_o, VEC[k][0] ? 3 : 2);
      xint_n = 2'b11;
      tick();
      check($sformatf("R7 back to sleep vec%0d", k), mode_o, 2);
    end

    // R7 stable raised together with the release is too late
    xint_en = 2'b01; xint_lvl = 2'b01; xint_n = 2'b10;
    tick();
    check("R6 waking mode", mode_o, 3);
    check("R6 waking osc/strobes", {osc_en, ale_mode, psen_mode}, 5'b11010);
    osc_stable = 1; xint_n = 2'b11;
    tick();
    check("R7 same-edge release", mode_o, 2);

    // R6 full handshake
    xint_n = 2'b10; tick();
    tick();
    xint_n = 2'b11; tick();
    check("R6 exit mode", mode_o, 0);
    check("R6 wake pulse", pd_wake, 1);
    tick();
    check("R6 pulse ends", pd_wake, 0);
    xint_en = 0; xint_lvl = 0;

    // R8 reset filter
    rst_pin = 1; tick(HOLD - 1); rst_pin = 0; tick();
    check("R8 short pulse", mode_o, 0);
    rst_pin = 1; tick(HOLD - 1);
    check("R8 one edge early", mode_o, 0);
    tick();
    check("R8 taken", mode_o, 4);
    check("R8 cpu/block", {cpu_clk_en, ram_wr_block}, 2'b01);
    rst_pin = 0; tick();
    check("R9 normal exit", mode_o, 0);
    check("R8 block clear", ram_wr_block, 0);

    // R9 test mode strap
    ale_in = 0; psen_in = 1; rst_pin = 1; tick(HOLD + 1);
    rst_pin = 0; tick();
    check("R9 mode", mode_o, 5);
    check("R9 pins", {port0_float, ports_weak_hi, ale_mode, psen_mode}, 6'b111111);
    check("R9 osc/cpu", {osc_en, cpu_clk_en}, 2'b10);
    ale_in = 1;

    // R10 test mode ignores requests
    idle_req = 1; pd_req = 1; irq_pending = 1;
    xint_en = 2'b11; xint_lvl = 2'b11; xint_n = 2'b00;
    tick();
    idle_req = 0; pd_req = 0; irq_pending = 0; xint_n = 2'b11;
    tick();
    check("R10 ignores requests", mode_o, 5);
    rst_pin = 1; tick(5); rst_pin = 0; tick();
    check("R10 ignores short reset", mode_o, 5);
    xint_en = 0; xint_lvl = 0;
    rst_pin = 1; tick(HOLD);
    check("R10 reset taken", mode_o, 4);
    rst_pin = 0; tick();
    check("R10 normal after", mode_o, 0);

    // R11 reset from light sleep
    idle_req = 1; tick(); idle_req = 0;
    rst_pin = 1; tick();
    check("R11 clock restarts", {mode_o, cpu_clk_en, ram_wr_block}, 5'b00011);
    tick(HOLD - 2);
    check("R11 still blocked", {mode_o, ram_wr_block}, 4'b0001);
    tick();
    check("R11 reset taken", mode_o, 4);
    rst_pin = 0; tick();
    check("R11 block cleared", {mode_o, ram_wr_block}, 4'b0000);
    idle_req = 1; tick(); idle_req = 0;
    rst_pin = 1; tick(3); rst_pin = 0; tick();
    check("R11 short pulse", {mode_o, ram_wr_block}, 4'b0000);

    // R12 reset from deep sleep
    pd_req = 1; tick(); pd_req = 0;
    osc_stable = 0; rst_pin = 1;
    #1 check("R12 osc restart", osc_en, 1);
    tick(30);
    check("R12 waits for stable", mode_o, 2);
    osc_stable = 1; tick(HOLD - 1);
    check("R12 one edge early", mode_o, 2);
    tick();
    check("R12 reset taken", mode_o, 4);
    rst_pin = 0; tick();
    check("R12 running", mode_o, 0);

    finish_run();
  end
endmodule